// File: doc/BRIEF.md
# Coherency Cluster Configuration Register Bank

This block is the software-visible register bank of a small multiprocessor cluster's coherency unit. It sits on a plain register bus. Each transfer has a byte address, a write strobe, a read strobe, a two-bit size code and 32-bit write data, and read data comes back one cycle later. The bank holds three things. The first is a one-bit enable. The second is a read-only word that reports how many CPUs the cluster was built with. The third is a 32-bit power status word with one byte per CPU. Software can update that word a byte, a halfword or a word at a time, starting at any of its four byte addresses. No caches, snoop filtering or coherency traffic live here.

The decoder maps each address onto one register class: enable, configuration, power status, invalidate, filter window, access control, or unmapped. A single `unique case` read multiplexer chooses the read value from that class. The bank has no sequencing state, so it has no state machine. Its only registers are the enable bit, the four power status lanes and the read data register. The CPU count parameter `NCPU` must lie in the range 1 to 4, and any other value stops elaboration with an error.

Top module: `snoop_regbank`

## Requirements
- R1: A valid-size write to address 0x00 stores only bit 0 of the write data. A read at 0x00 returns that bit in bit 0 and zeros in bits 31:1.
- R2: A read at 0x04 returns `((2^NCPU - 1) << 4) | (NCPU - 1)`, which is 0x72 for NCPU = 3. Writes to 0x04 change nothing.
- R3: A write at 0x08+k (k = 0..3) replaces power status bytes k and up. It writes one byte for size 0, two bytes for size 1 and four bytes for size 2, taking them from the low bytes of the write data in order. Lanes past byte 3 are dropped, and all other status bytes keep their value.
- R4: A read at 0x08+k returns the power status word shifted right by 8*k bits, with zeros filled in from the top.
- R5: Reads at 0x0C, at 0x40, 0x44, 0x50 and 0x54, and at every other address outside 0x00, 0x04 and 0x08..0x0B return zero. Writes to those addresses change no register.
- R6: A write with size code 3 changes no register at any address.
- R7: Reset clears the enable bit and the read data register. The power status word keeps its value through reset, and it starts at zero at power-on.
- R8: Read data is loaded at the clock edge that samples the read strobe and is valid from the following cycle. It holds its value while the read strobe is low. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address within the 256-byte window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the bank with three CPUs. It sweeps all 256 addresses with all four size codes, writing a pattern that differs for each address and size and then reading back both the addressed location and the full status word at 0x08. The sweep exercises every status offset with every size, so it catches masks that are too wide, shifts from the wrong base and words that wrap past byte 3. The same sweep confirms that no unmapped or invalid-size write leaks into the enable bit or the status word. A reset taken while both the enable bit and the status word hold non-zero values separates the register that reset clears from the one it keeps. An idle cycle after each read shows that read data holds its value.

// File: rtl/snoop_regbank_pkg.sv
package snoop_regbank_pkg;

    typedef enum logic [2:0] {
        SEL_ENABLE,
        SEL_CONFIG,
        SEL_POWER,
        SEL_INVAL,
        SEL_FILTER,
        SEL_ACCESS,
        SEL_UNMAPPED
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // number of byte lanes a size code covers (0 for the invalid code)
    function automatic int size_bytes(acc_size_e sz);
        unique case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/snoop_addr_decode.sv
module snoop_addr_decode
    import snoop_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [1:0]        lane_ofs
);

    always_comb begin
        lane_ofs = addr[1:0];
        unique case (addr)
            ADDR_W'('h00): sel = SEL_ENABLE;
            ADDR_W'('h04): sel = SEL_CONFIG;
            ADDR_W'('h08),
            ADDR_W'('h09),
            ADDR_W'('h0A),
            ADDR_W'('h0B): sel = SEL_POWER;
            ADDR_W'('h0C): sel = SEL_INVAL;
            ADDR_W'('h40),
            ADDR_W'('h44): sel = SEL_FILTER;
            ADDR_W'('h50),
            ADDR_W'('h54): sel = SEL_ACCESS;
            default:       sel = SEL_UNMAPPED;
        endcase
    end

endmodule

// File: rtl/snoop_pwr_lanes.sv
module snoop_pwr_lanes
    import snoop_regbank_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [1:0]         lane_ofs,
    input  acc_size_e          size,
    input  logic [8*LANES-1:0] wdata,
    output logic [8*LANES-1:0] status
);

    localparam int WORD_W = 8 * LANES;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_q = '0;
        logic       hit;
        logic [7:0] lane_d;

        always_comb begin
            int rel;
            rel    = i - int'(lane_ofs);
            hit    = 1'b0;
            lane_d = lane_q;
            if (rel >= 0 && rel < size_bytes(size)) begin
                hit    = 1'b1;
                lane_d = wdata[rel*8 +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (wr_stb && hit) begin
                lane_q <= lane_d;
            end
        end

        assign status[8*i +: 8] = lane_q;
    end

    // R3
    pwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(status));

    // R3
    pwr_byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && size == SZ_BYTE) |=>
            (((status ^ $past(status)) & ~(WORD_W'('hFF) << (8 * $past(lane_ofs)))) == '0));

endmodule

// File: rtl/snoop_regbank.sv
module snoop_regbank
    import snoop_regbank_pkg::*;
#(
    parameter int NCPU   = 1,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int          LANES    = 4;
    localparam logic [31:0] CFG_WORD = (32'((1 << NCPU) - 1) << 4) | 32'(NCPU - 1);

    if (NCPU < 1 || NCPU > LANES) begin : g_bad_ncpu
        $error("snoop_regbank: NCPU must be within 1..4");
    end

    reg_sel_e    sel;
    logic [1:0]  lane_ofs;
    acc_size_e   size;
    logic        wr_ok;
    logic        enable_q;
    logic [31:0] status;
    logic [31:0] rd_next;
    logic [31:0] rdata_q;

    assign size  = acc_size_e'(bus_size);
    assign wr_ok = bus_wr && (size != SZ_BAD);

    snoop_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .sel      (sel),
        .lane_ofs (lane_ofs)
    );

    snoop_pwr_lanes #(.LANES(LANES)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_ok && sel == SEL_POWER),
        .lane_ofs (lane_ofs),
        .size     (size),
        .wdata    (bus_wdata),
        .status   (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (wr_ok && sel == SEL_ENABLE) begin
            enable_q <= bus_wdata[0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rd_next = {31'b0, enable_q};
            SEL_CONFIG: rd_next = CFG_WORD;
            SEL_POWER:  rd_next = status >> (8 * lane_ofs);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;

    // R1
    enable_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h00)) |=> (bus_rdata[31:1] == '0));

    // R2
    config_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h04)) |=> (bus_rdata == CFG_WORD));

    // R5
    raz_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_INVAL || sel == SEL_FILTER || sel == SEL_ACCESS
                    || sel == SEL_UNMAPPED)) |=> (bus_rdata == '0));

    // R6
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size == 2'd3) |=> ($stable(enable_q) && $stable(status)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/snoop_regbank_test.sv
`timescale 1ns/1ps
module snoop_regbank_test;

    localparam int NCPU = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        m_enable = 1'b0;
    logic [31:0] m_status = '0;

    always #2 clk = ~clk;

    snoop_regbank #(.NCPU(NCPU), .ADDR_W(8)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] cfg_expect();
        return (((32'd1 << NCPU) - 32'd1) << 4) | 32'(NCPU - 1);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h00) return {31'b0, m_enable};
        if (a == 8'h04) return cfg_expect();
        if (a >= 8'h08 && a <= 8'h0B) return m_status >> (8 * (a - 8'h08));
        return 32'h0;
    endfunction

    task automatic model_write(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
        logic [63:0] mask;
        logic [63:0] data;
        if (sz == 2'd3) return;
        if (a == 8'h00) m_enable = d[0];
        if (a >= 8'h08 && a <= 8'h0B) begin
            mask = (sz == 2'd0) ? 64'hFF : (sz == 2'd1) ? 64'hFFFF : 64'hFFFF_FFFF;
            data = {32'h0, d} & mask;
            mask = mask << (8 * (a - 8'h08));
            data = data << (8 * (a - 8'h08));
            m_status = (m_status & ~mask[31:0]) | data[31:0];
        end
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(logic [7:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, model_read(a));
    endtask

    function automatic string tag_for(logic [7:0] a, logic [1:0] sz);
        if (sz == 2'd3) return "R6";
        if (a == 8'h00) return "R1";
        if (a == 8'h04) return "R2";
        if (a >= 8'h08 && a <= 8'h0B) return "R3";
        return "R5";
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R7: read data cleared by reset, power status zero at power-on
        check("R7 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h00, "R7 enable after reset");
        do_read(8'h08, "R7 status at power-on");
        do_read(8'h04, "R2 config word");
        check("R2 config constant", bus_rdata, 32'h0000_0072);

        // R1: only bit 0 stored
        do_write(8'h00, 2'd2, 32'hFFFF_FFFE);
        do_read(8'h00, "R1 even data");
        do_write(8'h00, 2'd0, 32'h0000_0003);
        do_read(8'h00, "R1 odd data");

        // R8: read data holds while strobe is low, and sees pre-write value
        held = bus_rdata;
        repeat (2) @(negedge clk);
        check("R8 hold", bus_rdata, held);
        @(negedge clk);
        bus_addr = 8'h00; bus_size = 2'd2; bus_wdata = 32'h0; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R8 read before write", bus_rdata, 32'h1);
        model_write(8'h00, 2'd2, 32'h0);

        // R3 / R4 corner: word write at 0x0B drops upper lanes
        do_write(8'h08, 2'd2, 32'h1122_3344);
        do_write(8'h0B, 2'd2, 32'hAABB_CCDD);
        do_read(8'h08, "R3 word past top");
        check("R3 word past top value", bus_rdata, 32'hDD22_3344);
        do_write(8'h09, 2'd1, 32'hFFFF_5566);
        do_read(8'h08, "R3 half at 0x09");
        check("R3 half at 0x09 value", bus_rdata, 32'hDD55_6644);
        for (int k = 0; k < 4; k++) begin
            do_read(8'(8 + k), "R4 shifted read");
        end

        // Exhaustive sweep: all addresses, all size codes
        for (int a = 0; a < 256; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                logic [31:0] pat;
                pat = 32'h9E37_79B9 * 32'(a * 4 + sz + 1);
                do_write(8'(a), 2'(sz), pat);
                do_read(8'(a), tag_for(8'(a), 2'(sz)));
                do_read(8'h08, (a >= 8 && a <= 11) ? "R3 full word" : "R5/R6 status untouched");
                do_read(8'h00, "R5/R6 enable untouched");
            end
        end

        // R7: reset clears enable only
        do_write(8'h00, 2'd0, 32'h1);
        do_write(8'h08, 2'd2, 32'hA5C3_0F96);
        @(negedge clk);
        rst_n = 1'b0;
        m_enable = 1'b0;
        @(negedge clk);
        check("R7 rdata cleared", bus_rdata, 32'h0);
        rst_n = 1'b1;
        do_read(8'h00, "R7 enable cleared");
        do_read(8'h08, "R7 status kept");
        check("R7 status kept value", bus_rdata, 32'hA5C3_0F96);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule